// File: doc/BRIEF.md
# Operand effective address generator

This block forms the memory address of a data operand. A request carries an addressing-mode code, a base register number, an index register number, a displacement field and an operand size (byte, word or long). The block reads the base and index registers from a 16-entry, 32-bit register file through two combinational read ports. It returns the address one clock later with a done pulse, an address-valid flag and a mode-illegal flag.

For the auto-modify modes the block also returns a register writeback request: the register number, the new value and a one-cycle enable. The register file owner applies it. Displacements and index values are scaled by the operand size. Every sum is truncated to 32 bits, so addresses wrap silently.

Top module: `oeag_top`

## Requirements
- R1: Mode code 0 (register indirect): the address is the 32-bit value of base register R0..R15.
- R2: Mode codes 1, 2 and 3 (register relative) take the low 5, 8 or 16 displacement bits and ignore the higher bits. The field is zero-extended and scaled by the size code: 0 = byte ×1, 1 = word ×2, 2 = long ×4. It is then added to the base register value.
- R3: With mode code 1 and a base register number of 8 or above, mode_illegal is 1, addr_valid is 0, addr is 0 and no writeback is issued.
- R4: Mode code 4 (post-increment): the address is the base value before the update. The writeback writes base + 1, 2 or 4 (according to size) to the base register.
- R5: Mode code 5 (pre-decrement): base − 1, 2 or 4 (according to size) is both the address and the writeback value for the base register.
- R6: Mode code 6 (indexed): the address is index register × 1, 2 or 4 (according to size) plus base register. Both may be any of R0..R15.
- R7: All address and writeback sums are taken modulo 2^32, with no flag or exception on carry or borrow.
- R8: wb_en pulses for exactly the done cycle of a legal mode-4 or mode-5 request, and is 0 for every other mode.
- R9: Mode code 7 or size code 3 makes the request illegal: mode_illegal is 1, addr_valid is 0, addr is 0 and wb_en is 0.
- R10: done is 1 in exactly the cycle after a clock edge that sampled req_valid high, and 0 otherwise. addr_valid equals done for a legal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled on the clock edge |
| req_mode | input | 3 | Addressing-mode code |
| req_base | input | 4 | Base register number |
| req_index | input | 4 | Index register number (mode 6) |
| req_disp | input | 16 | Displacement field |
| req_size | input | 2 | Operand size code |
| rf_raddr_a | output | 4 | Register file read address, base |
| rf_raddr_b | output | 4 | Register file read address, index |
| rf_rdata_a | input | 32 | Base register value |
| rf_rdata_b | input | 32 | Index register value |
| done | output | 1 | Result pulse, one cycle after the request |
| addr | output | 32 | Effective address |
| addr_valid | output | 1 | Address is usable |
| mode_illegal | output | 1 | Request used a forbidden combination |
| wb_en | output | 1 | Register writeback enable |
| wb_idx | output | 4 | Register to write back |
| wb_data | output | 32 | Value to write back |

## Verification
The bench builds the block with its default parameters: a 16-bit displacement field, 5- and 8-bit short forms, and the short-form base limit at 8. The 16-bit field lets a long-scaled displacement carry past bit 16 and bit 17. The limit of 8 puts the R7-legal and R8-illegal boundary of mode 1 in reach. Register values near 0 and near FFFFFFFFh exercise wraparound in both directions. Register contents written back by one request are read by later requests, so a wrong writeback shows up in later addresses.

// File: rtl/oeag_pkg.sv
package oeag_pkg;
    localparam int ADDR_W    = 32;
    localparam int REG_IDX_W = 4;

    typedef enum logic [2:0] {
        AM_IND     = 3'd0,
        AM_REL_S   = 3'd1,
        AM_REL_M   = 3'd2,
        AM_REL_L   = 3'd3,
        AM_POSTINC = 3'd4,
        AM_PREDEC  = 3'd5,
        AM_INDEXED = 3'd6,
        AM_RSVD    = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } osize_e;

    typedef struct packed {
        logic [ADDR_W-1:0]    addr;
        logic                 illegal;
        logic                 wb_req;
        logic [REG_IDX_W-1:0] wb_idx;
        logic [ADDR_W-1:0]    wb_data;
    } ea_result_t;

    function automatic logic [ADDR_W-1:0] size_step(osize_e sz);
        case (sz)
            SZ_BYTE: size_step = ADDR_W'(1);
            SZ_WORD: size_step = ADDR_W'(2);
            SZ_LONG: size_step = ADDR_W'(4);
            default: size_step = '0;
        endcase
    endfunction
endpackage

// File: rtl/oeag_scaler.sv
module oeag_scaler
    import oeag_pkg::*;
(
    input  logic [ADDR_W-1:0] val_in,
    input  osize_e            size,
    output logic [ADDR_W-1:0] val_out
);
    always_comb begin
        case (size)
            SZ_WORD: val_out = val_in << 1;
            SZ_LONG: val_out = val_in << 2;
            default: val_out = val_in;
        endcase
    end
endmodule

// File: rtl/oeag_addr_calc.sv
module oeag_addr_calc
    import oeag_pkg::*;
#(
    parameter int DISP_W           = 16,
    parameter int SHORT_DISP_W     = 5,
    parameter int MID_DISP_W       = 8,
    parameter int SHORT_BASE_LIMIT = 8
) (
    input  amode_e               mode,
    input  osize_e               size,
    input  logic [REG_IDX_W-1:0] base_idx,
    input  logic [DISP_W-1:0]    disp,
    input  logic [ADDR_W-1:0]    base_val,
    input  logic [ADDR_W-1:0]    index_val,
    output ea_result_t           res
);
    localparam int N_SCALE = 2;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] sc_in  [N_SCALE];
    logic [ADDR_W-1:0] sc_out [N_SCALE];
    logic [ADDR_W-1:0] step;
    logic              bad;

    always_comb begin
        case (mode)
            AM_REL_S: disp_ext = ADDR_W'(disp[SHORT_DISP_W-1:0]);
            AM_REL_M: disp_ext = ADDR_W'(disp[MID_DISP_W-1:0]);
            default:  disp_ext = ADDR_W'(disp);
        endcase
    end

    assign sc_in[0] = disp_ext;
    assign sc_in[1] = index_val;

    for (genvar g = 0; g < N_SCALE; g++) begin : g_scale
        oeag_scaler u_scaler (
            .val_in (sc_in[g]),
            .size   (size),
            .val_out(sc_out[g])
        );
    end

    assign step = size_step(size);

    always_comb begin
        res        = '0;
        res.wb_idx = base_idx;
        bad        = (size == SZ_RSVD);
        case (mode)
            AM_IND: res.addr = base_val;
            AM_REL_S: begin
                res.addr = base_val + sc_out[0];
                if (int'(base_idx) >= SHORT_BASE_LIMIT) bad = 1'b1;
            end
            AM_REL_M, AM_REL_L: res.addr = base_val + sc_out[0];
            AM_POSTINC: begin
                res.addr    = base_val;
                res.wb_req  = 1'b1;
                res.wb_data = base_val + step;
            end
            AM_PREDEC: begin
                res.wb_data = base_val - step;
                res.addr    = res.wb_data;
                res.wb_req  = 1'b1;
            end
            AM_INDEXED: res.addr = base_val + sc_out[1];
            default: bad = 1'b1;
        endcase
        if (bad) begin
            res.addr    = '0;
            res.wb_req  = 1'b0;
            res.wb_data = '0;
        end
        res.illegal = bad;
    end
endmodule

// File: rtl/oeag_result_reg.sv
module oeag_result_reg
    import oeag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  ea_result_t nxt,
    output ea_result_t cur,
    output logic       done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            done <= 1'b0;
        end else begin
            done <= capture;
            if (capture) cur <= nxt;
        end
    end
endmodule

// File: rtl/oeag_top.sv
module oeag_top
    import oeag_pkg::*;
#(
    parameter int DISP_W           = 16,
    parameter int SHORT_DISP_W     = 5,
    parameter int MID_DISP_W       = 8,
    parameter int SHORT_BASE_LIMIT = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [2:0]           req_mode,
    input  logic [REG_IDX_W-1:0] req_base,
    input  logic [REG_IDX_W-1:0] req_index,
    input  logic [DISP_W-1:0]    req_disp,
    input  logic [1:0]           req_size,
    output logic [REG_IDX_W-1:0] rf_raddr_a,
    output logic [REG_IDX_W-1:0] rf_raddr_b,
    input  logic [ADDR_W-1:0]    rf_rdata_a,
    input  logic [ADDR_W-1:0]    rf_rdata_b,
    output logic                 done,
    output logic [ADDR_W-1:0]    addr,
    output logic                 addr_valid,
    output logic                 mode_illegal,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [ADDR_W-1:0]    wb_data
);
    ea_result_t calc_res;
    ea_result_t held;

    assign rf_raddr_a = req_base;
    assign rf_raddr_b = req_index;

    oeag_addr_calc #(
        .DISP_W          (DISP_W),
        .SHORT_DISP_W    (SHORT_DISP_W),
        .MID_DISP_W      (MID_DISP_W),
        .SHORT_BASE_LIMIT(SHORT_BASE_LIMIT)
    ) u_calc (
        .mode     (amode_e'(req_mode)),
        .size     (osize_e'(req_size)),
        .base_idx (req_base),
        .disp     (req_disp),
        .base_val (rf_rdata_a),
        .index_val(rf_rdata_b),
        .res      (calc_res)
    );

    oeag_result_reg u_hold (
        .clk    (clk),
        .rst    (rst),
        .capture(req_valid),
        .nxt    (calc_res),
        .cur    (held),
        .done   (done)
    );

    assign addr         = held.addr;
    assign mode_illegal = done & held.illegal;
    assign addr_valid   = done & ~held.illegal;
    assign wb_en        = done & held.wb_req;
    assign wb_idx       = held.wb_idx;
    assign wb_data      = held.wb_data;

    // R10
    done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done);
    // R10
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !done);
    // R8
    wb_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (done && addr_valid));
    // R9
    illegal_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        mode_illegal |-> (!addr_valid && !wb_en));
    // R1
    indirect_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd0 && req_size != 2'd3)
        |=> (addr == $past(rf_rdata_a)));
    // R4
    postinc_old_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd4 && req_size != 2'd3)
        |=> (addr == $past(rf_rdata_a) && wb_en));
    // R5
    predec_same_val_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd5 && req_size != 2'd3)
        |=> (addr == wb_data && wb_idx == $past(req_base)));
endmodule

// File: tb/oeag_top_tb.sv
module oeag_top_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int          due;
        string       tag;
        logic [31:0] addr;
        logic        illegal;
        logic        wb;
        logic [3:0]  widx;
        logic [31:0] wdata;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [3:0]  req_base = '0;
    logic [3:0]  req_index = '0;
    logic [15:0] req_disp = '0;
    logic [1:0]  req_size = '0;
    logic [3:0]  rf_raddr_a, rf_raddr_b;
    logic [31:0] rf_rdata_a, rf_rdata_b;
    logic        done, addr_valid, mode_illegal, wb_en;
    logic [31:0] addr, wb_data;
    logic [3:0]  wb_idx;

    logic [31:0] regs [16];
    exp_t        q[$];
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rdata_a = regs[rf_raddr_a];
    assign rf_rdata_b = regs[rf_raddr_b];

    oeag_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_base(req_base), .req_index(req_index), .req_disp(req_disp),
        .req_size(req_size), .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b), .done(done),
        .addr(addr), .addr_valid(addr_valid), .mode_illegal(mode_illegal),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Reference model: compared on every falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(done === 1'b1, e.tag, "done", 32'(done), 1);
                chk(mode_illegal === e.illegal, e.tag, "mode_illegal",
                    32'(mode_illegal), 32'(e.illegal));
                chk(addr_valid === !e.illegal, e.tag, "addr_valid",
                    32'(addr_valid), 32'(!e.illegal));
                chk(addr === e.addr, e.tag, "addr", addr, e.addr);
                chk(wb_en === e.wb, {e.tag, "/R8"}, "wb_en", 32'(wb_en), 32'(e.wb));
                if (e.wb) begin
                    chk(wb_idx === e.widx, e.tag, "wb_idx", 32'(wb_idx), 32'(e.widx));
                    chk(wb_data === e.wdata, e.tag, "wb_data", wb_data, e.wdata);
                end
            end else begin
                // R10: no result without a request
                chk(done === 1'b0 && wb_en === 1'b0 && addr_valid === 1'b0,
                    "R10", "idle done/wb_en/addr_valid",
                    {29'd0, done, wb_en, addr_valid}, 32'd0);
            end
        end
    end

    function automatic exp_t model(input logic [2:0] m, input logic [1:0] sz,
                                   input logic [3:0] b, input logic [3:0] x,
                                   input logic [15:0] d);
        exp_t e;
        longint unsigned rb, rx, st, sum;
        rb = 64'(regs[b]);
        rx = 64'(regs[x]);
        st = 64'(1) << sz;
        e.illegal = (sz == 2'd3);
        e.wb = 1'b0;
        e.widx = b;
        e.wdata = '0;
        sum = 0;
        case (m)
            3'd0: begin sum = rb; e.tag = "R1"; end
            3'd1: begin sum = rb + 64'(d % 32) * st; e.tag = "R2";
                        if (b > 7) begin e.illegal = 1'b1; e.tag = "R3"; end end
            3'd2: begin sum = rb + 64'(d % 256) * st; e.tag = "R2"; end
            3'd3: begin sum = rb + 64'(d) * st; e.tag = "R2"; end
            3'd4: begin sum = rb; e.wb = 1'b1; e.wdata = 32'((rb + st) % 64'h1_0000_0000);
                        e.tag = "R4"; end
            3'd5: begin sum = (rb + 64'h1_0000_0000 - st); e.wb = 1'b1;
                        e.wdata = 32'(sum % 64'h1_0000_0000); e.tag = "R5"; end
            3'd6: begin sum = rb + rx * st; e.tag = "R6"; end
            default: begin e.illegal = 1'b1; e.tag = "R9"; end
        endcase
        if (sz == 2'd3) e.tag = "R9";
        e.addr = 32'(sum % 64'h1_0000_0000);
        if (e.illegal) begin e.addr = '0; e.wb = 1'b0; end
        return e;
    endfunction

    task automatic issue(input logic [2:0] m, input logic [1:0] sz,
                         input logic [3:0] b, input logic [3:0] x,
                         input logic [15:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_size = sz;
        req_base = b; req_index = x; req_disp = d;
        e = model(m, sz, b, x, d);
        if (tag != "") e.tag = tag;
        e.due = cyc + 1;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (e.wb) regs[e.widx] = e.wdata;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h100;
        regs[3]  = 32'h1234_5678;
        regs[6]  = 32'h0000_0000;
        regs[9]  = 32'hFFFF_FF00;
        regs[10] = 32'h4000_0050;
        regs[11] = 32'hFFFF_FFF0;
        repeat (3) @(negedge clk);
        // Reset state
        chk(done === 1'b0 && addr_valid === 1'b0 && wb_en === 1'b0 && mode_illegal === 1'b0,
            "R10", "reset outputs", {28'd0, done, addr_valid, wb_en, mode_illegal}, 0);
        rst = 1'b0;
        issue(3'd0, 2'd2, 4'd3, 4'd0, 16'h0000, "R1");
        issue(3'd2, 2'd1, 4'd2, 4'd0, 16'hAB80, "R2");
        issue(3'd3, 2'd2, 4'd4, 4'd0, 16'hFFFF, "R2");
        issue(3'd1, 2'd0, 4'd5, 4'd0, 16'hFFE3, "R2");
        issue(3'd1, 2'd2, 4'd7, 4'd0, 16'h001F, "R2");
        issue(3'd1, 2'd0, 4'd8, 4'd0, 16'h0001, "R3");
        issue(3'd4, 2'd2, 4'd5, 4'd0, 16'h0000, "R4");
        issue(3'd0, 2'd0, 4'd5, 4'd0, 16'h0000, "R4");
        issue(3'd4, 2'd0, 4'd5, 4'd0, 16'h0000, "R4");
        issue(3'd5, 2'd1, 4'd6, 4'd0, 16'h0000, "R5");
        issue(3'd0, 2'd0, 4'd6, 4'd0, 16'h0000, "R5");
        issue(3'd6, 2'd2, 4'd9, 4'd10, 16'h0000, "R6");
        issue(3'd6, 2'd0, 4'd15, 4'd15, 16'h0000, "R6");
        issue(3'd3, 2'd2, 4'd11, 4'd0, 16'h0020, "R7");
        issue(3'd4, 2'd2, 4'd11, 4'd0, 16'h0000, "R7");
        issue(3'd7, 2'd0, 4'd2, 4'd0, 16'h0000, "R9");
        issue(3'd4, 2'd3, 4'd2, 4'd0, 16'h0000, "R9");
        issue(3'd0, 2'd0, 4'd2, 4'd0, 16'h0000, "R9");
        for (int n = 0; n < 400; n++) begin
            issue(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                  4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                  16'($urandom), "");
            if (n % 50 == 0) regs[$urandom_range(0, 15)] = $urandom;
        end
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R10", "pending results", 32'(q.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule